// File: doc/BRIEF.md
# ADC Serial Readout Host Controller

This block is the host-side sequencer for a successive-approximation converter. The converter runs in a four-wire mode where the chip-select line doubles as the serial data input, and it flags the end of each conversion on its data line. The controller drives three lines into the converter: the convert strobe, the select/data-in line and the serial clock. It watches the converter's data line, which has a pull-up and so reads high while it floats. A start request makes the controller raise the convert strobe with select high, which arms a conversion. It then drops select so that the converter will report completion on its data line.

Completion is a falling level on the data line, seen through a synchroniser. On that level the controller clocks out one 16-bit sample, most significant bit first. It then raises select to float the line again, lowers the convert strobe and returns to idle. The sample is offered on a valid/ready output. A timeout guards the wait for completion. The serial clock half-period and the timeout length come from the user side as plain inputs.

Back-pressure rules: `smp_valid_o` stays high, with `smp_data_o` held, until a cycle in which `smp_ready_i` is high. While a sample is waiting there, a start request is not accepted. No new conversion begins until the sample is taken, so no sample is ever dropped or overwritten.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: After reset, and whenever idle, the convert strobe and serial clock are low, select is high, and both `smp_valid_o` and `conv_timeout_o` are low.
- R2: A start request accepted in idle raises the convert strobe with select high. Select then stays high for exactly ARM_CYC cycles (default 3), counted from the strobe's rising cycle, and is then driven low.
- R3: The serial clock is high only while the convert strobe is high and select is low.
- R4: The first high-to-low change of the synchronised data line after select goes low starts readback. Readback is exactly W+1 = 17 serial clock pulses, low phase first. Each phase lasts max(`cfg_half_i`, 2) system clocks.
- R5: The data line is sampled at the moment each serial clock pulse falls. Pulse 1 carries the busy bit, which is discarded. Pulses 2 to 17 carry bit 15 down to bit 0, and bit 15 is the MSB of `smp_data_o`.
- R6: After the last pulse, select is driven high while the convert strobe is still high. The convert strobe falls one cycle later.
- R7: A finished sample raises `smp_valid_o`. `smp_valid_o` and `smp_data_o` hold until `smp_ready_i` is high. A start request while a sample is waiting creates no convert strobe edge.
- R8: If no completion edge appears within `cfg_timeout_i` cycles of select going low, `conv_timeout_o` pulses for one cycle, exactly ARM_CYC + `cfg_timeout_i` cycles after the strobe's rising cycle. No sample is produced, and the R6 closing order applies.
- R9: Start requests during a conversion or readback are ignored, so a held start produces exactly one convert strobe rise per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion and readback |
| cfg_half_i | input | HALF_W (8) | Serial clock half-period in system clocks, minimum 2 applied |
| cfg_timeout_i | input | TO_W (20) | Cycles allowed for completion after select goes low, at least 1 |
| cnv_o | output | 1 | Convert strobe to the converter |
| sdi_o | output | 1 | Select / data-in line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdo_i | input | 1 | Converter data line, pulled high when floating |
| smp_valid_o | output | 1 | Sample available |
| smp_ready_i | input | 1 | Consumer accepts the sample |
| smp_data_o | output | W (16) | Captured sample, MSB first on the wire |
| conv_timeout_o | output | 1 | One-cycle pulse when completion never arrives |

## Verification
Each failure mode of the internal state shows up at the pins within one frame. A sequencer in the wrong state makes serial clock edges appear while select is high. It also shows as a wrong pulse count between the strobe edges, or as a strobe that drops before select has risen. A capture counter that is off by one shifts the word by one bit position, so the wrong sample appears on the very next valid handshake. A broken timeout counter shows as a missing pulse, or one at a cycle other than ARM_CYC plus the programmed limit. A lost back-pressure hold shows as a sample changing or vanishing while ready is low.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARM     = 3'd1,
    ST_WAIT    = 3'd2,
    ST_SHIFT   = 3'd3,
    ST_RELEASE = 3'd4
  } rd_state_e;

  // Busy bit plus one pulse per data bit
  function automatic int unsigned sck_pulses(input int unsigned width);
    return width + 1;
  endfunction
endpackage

// File: rtl/adc_line_sync.sv
module adc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Line idles high (pull-up), so reset to 1 avoids a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/adc_sck_pacer.sv
module adc_sck_pacer #(
  parameter int HALF_W   = 8,
  parameter int N_PULSES = 17,
  parameter int MIN_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              sck_o,
  output logic              fall_o,
  output logic              first_o,
  output logic              last_o
);
  localparam int PC_W = $clog2(N_PULSES + 1);

  logic [HALF_W-1:0] half_eff;
  logic [HALF_W-1:0] cnt_q;
  logic [PC_W-1:0]   nfall_q;
  logic              sck_q;
  logic              phase_end;

  assign half_eff  = (half_i < HALF_W'(MIN_HALF)) ? HALF_W'(MIN_HALF) : half_i;
  assign phase_end = (cnt_q == half_eff - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      nfall_q <= '0;
      sck_q   <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      nfall_q <= '0;
      sck_q   <= 1'b0;
    end else if (phase_end) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
      if (sck_q) nfall_q <= nfall_q + PC_W'(1);
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  assign sck_o   = sck_q;
  assign fall_o  = en_i & sck_q & phase_end;
  assign first_o = (nfall_q == '0);
  assign last_o  = fall_o & (nfall_q == PC_W'(N_PULSES - 1));
endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_next_o
);
  logic [W-1:0] shreg_q;

  assign word_next_o = {shreg_q[W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shreg_q <= '0;
    else if (clr_i)   shreg_q <= '0;
    else if (shift_i) shreg_q <= word_next_o;
  end
endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
  import adc_rdout_pkg::*;
#(
  parameter int W           = 16,
  parameter int HALF_W      = 8,
  parameter int TO_W        = 20,
  parameter int ARM_CYC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [HALF_W-1:0] cfg_half_i,
  input  logic [TO_W-1:0]   cfg_timeout_i,
  output logic              cnv_o,
  output logic              sdi_o,
  output logic              sck_o,
  input  logic              sdo_i,
  output logic              smp_valid_o,
  input  logic              smp_ready_i,
  output logic [W-1:0]      smp_data_o,
  output logic              conv_timeout_o
);
  localparam int N_SCK = sck_pulses(W);
  localparam int ARM_W = $clog2(ARM_CYC + 1);

  rd_state_e    state_q, state_d;
  logic [ARM_W-1:0] arm_cnt_q;
  logic [TO_W-1:0]  to_cnt_q;
  logic         cnv_q, sdi_q, err_q, vld_q;
  logic [W-1:0] data_q;

  logic sdo_lvl, sdo_fall;
  logic sck_en, sck_fall, sck_first, sck_last;
  logic [W-1:0] word_next;
  logic start_ok, arm_done, to_hit;

  adc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (sdo_i),
    .lvl_o  (sdo_lvl),
    .fall_o (sdo_fall)
  );

  assign sck_en = (state_q == ST_SHIFT);

  adc_sck_pacer #(.HALF_W(HALF_W), .N_PULSES(N_SCK), .MIN_HALF(2)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (sck_en),
    .half_i  (cfg_half_i),
    .sck_o   (sck_o),
    .fall_o  (sck_fall),
    .first_o (sck_first),
    .last_o  (sck_last)
  );

  adc_bit_capture #(.W(W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (state_q == ST_WAIT),
    .shift_i     (sck_fall & ~sck_first),
    .bit_i       (sdo_lvl),
    .word_next_o (word_next)
  );

  assign start_ok = (state_q == ST_IDLE) && start_i && !vld_q;
  assign arm_done = (arm_cnt_q == ARM_W'(ARM_CYC - 1));
  assign to_hit   = (to_cnt_q == cfg_timeout_i - TO_W'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_ok) state_d = ST_ARM;
      ST_ARM:     if (arm_done) state_d = ST_WAIT;
      ST_WAIT: begin
        if (sdo_fall)    state_d = ST_SHIFT;
        else if (to_hit) state_d = ST_RELEASE;
      end
      ST_SHIFT:   if (sck_last) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      arm_cnt_q <= '0;
      to_cnt_q  <= '0;
      cnv_q     <= 1'b0;
      sdi_q     <= 1'b1;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      arm_cnt_q <= (state_q == ST_ARM)  ? arm_cnt_q + ARM_W'(1) : '0;
      to_cnt_q  <= (state_q == ST_WAIT) ? to_cnt_q + TO_W'(1)   : '0;
      cnv_q     <= (state_d != ST_IDLE);
      sdi_q     <= (state_d == ST_IDLE) || (state_d == ST_ARM) ||
                   (state_d == ST_RELEASE);
      err_q     <= (state_q == ST_WAIT) && !sdo_fall && to_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (sck_en && sck_last) begin
      vld_q  <= 1'b1;
      data_q <= word_next;
    end else if (smp_ready_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign cnv_o          = cnv_q;
  assign sdi_o          = sdi_q;
  assign smp_valid_o    = vld_q;
  assign smp_data_o     = data_q;
  assign conv_timeout_o = err_q;
endmodule

// File: rtl/adc_rdout_ctrl_chk.sv
module adc_rdout_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnv_o,
  input logic         sdi_o,
  input logic         sck_o,
  input logic         smp_valid_o,
  input logic         smp_ready_i,
  input logic [W-1:0] smp_data_o,
  input logic         conv_timeout_o
);
  a_r3_sck_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> (cnv_o && !sdi_o));

  a_r2_select_high_at_convert: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> sdi_o);

  a_r6_release_before_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> $past(sdi_o));

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_data_o)));

  a_r7_no_start_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> !$past(smp_valid_o));

  a_r8_timeout_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_timeout_o |=> !conv_timeout_o);

  a_r8_timeout_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    conv_timeout_o |-> (!smp_valid_o && cnv_o && sdi_o));
endmodule

bind adc_rdout_ctrl adc_rdout_ctrl_chk #(.W(W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cnv_o          (cnv_o),
  .sdi_o          (sdi_o),
  .sck_o          (sck_o),
  .smp_valid_o    (smp_valid_o),
  .smp_ready_i    (smp_ready_i),
  .smp_data_o     (smp_data_o),
  .conv_timeout_o (conv_timeout_o)
);

// File: tb/adc_rdout_ctrl_tb.sv
module adc_rdout_ctrl_tb;
  localparam int W = 16, HALF_W = 8, TO_W = 20, ARM = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ready = 1'b1;
  logic [HALF_W-1:0] cfg_half = 8'd3;
  logic [TO_W-1:0]   cfg_to = 20'd200;
  logic cnv, sdi, sck, sdo_line, vld, err;
  logic [W-1:0] data;

  always #10 clk = ~clk;

  adc_rdout_ctrl #(.W(W), .HALF_W(HALF_W), .TO_W(TO_W), .ARM_CYC(ARM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_half_i(cfg_half),
    .cfg_timeout_i(cfg_to), .cnv_o(cnv), .sdi_o(sdi), .sck_o(sck),
    .sdo_i(sdo_line), .smp_valid_o(vld), .smp_ready_i(ready),
    .smp_data_o(data), .conv_timeout_o(err)
  );

  // converter model
  int m_phase = 0, m_left = 0, m_idx = 0, m_ctime = 20;
  logic m_drive = 1'b0, m_val = 1'b1, m_mute = 1'b0;
  logic [W-1:0] m_word = '0;
  assign sdo_line = m_drive ? m_val : 1'b1;

  // monitor state
  int cyc = 0, cnv_rises = 0, rise_cyc = 0, arm_len = 0, pulses = 0;
  int sck_rise_cyc = 0, hi_len = 0, bad_sck = 0, bad_close = 0;
  int got_cnt = 0, err_cnt = 0, err_cyc = 0;
  logic [W-1:0] got_word = '0;
  logic p_cnv = 1'b0, p_sck = 1'b0, p_sdi = 1'b1;
  int nchk = 0, nbad = 0;

  always @(negedge clk) begin
    if (cnv && !p_cnv && sdi) begin
      m_phase = 1; m_left = m_ctime; m_drive = 1'b0;
    end else if (!cnv && p_cnv) begin
      m_phase = 0; m_drive = 1'b0;
    end else if (m_phase == 1) begin
      if (m_left > 1) m_left--;
      else if (!sdi && !m_mute) begin
        m_phase = 2; m_drive = 1'b1; m_val = 1'b0; m_idx = 0;
      end else m_phase = 0;
    end else if (m_phase == 2) begin
      if (sdi && !p_sdi) begin
        m_phase = 0; m_drive = 1'b0;
      end else if (p_sck && !sck) begin
        m_idx++;
        if (m_idx <= W) m_val = m_word[W-m_idx];
        else begin m_drive = 1'b0; m_phase = 0; end
      end
    end
    if (cnv && !p_cnv) begin cnv_rises++; rise_cyc = cyc; pulses = 0; end
    if (!sdi && p_sdi && cnv) arm_len = cyc - rise_cyc;
    if (sck && !p_sck) begin
      pulses++; sck_rise_cyc = cyc;
      if (sdi || !cnv) bad_sck++;
    end
    if (!sck && p_sck && pulses == 1) hi_len = cyc - sck_rise_cyc;
    if (!cnv && p_cnv && !p_sdi) bad_close++;
    if (vld && ready) begin got_cnt++; got_word = data; end
    if (err) begin err_cnt++; err_cyc = cyc - rise_cyc; end
    p_cnv = cnv; p_sck = sck; p_sdi = sdi; cyc++;
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_half(int h);
    return (h < 2) ? 2 : h;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic frame(logic [W-1:0] w, int half, int ctime, logic mute,
                       int to, logic hold_start);
    int b_rise, b_got, b_err, guard;
    m_word = w; m_ctime = ctime; m_mute = mute;
    cfg_half = HALF_W'(half); cfg_to = TO_W'(to);
    b_rise = cnv_rises; b_got = got_cnt; b_err = err_cnt;
    start = 1'b1;
    if (!hold_start) begin tick(1); start = 1'b0; end
    guard = 0;
    while (got_cnt == b_got && err_cnt == b_err && guard < 5000) begin
      tick(1); guard++;
    end
    start = 1'b0;
    tick(4);
    chk("R9 one convert edge per frame", cnv_rises - b_rise, 1);
    chk("R6 strobe low after frame", int'(cnv), 0);
    chk("R2 select high cycles", arm_len, ARM);
    if (!mute && ctime < to) begin
      chk("R5 sample word", int'(got_word), int'(w));
      chk("R4 pulse count", pulses, W + 1);
      chk("R4 high phase length", hi_len, exp_half(half));
      chk("R8 no timeout", err_cnt - b_err, 0);
    end else begin
      chk("R8 timeout pulse", err_cnt - b_err, 1);
      chk("R8 timeout cycle", err_cyc, ARM + to);
      chk("R8 no sample", got_cnt - b_got, 0);
      chk("R8 no clock", pulses, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nbad++; nchk++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0a1c);
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 reset strobe", int'(cnv), 0);
    chk("R1 reset clock", int'(sck), 0);
    chk("R1 reset select", int'(sdi), 1);
    chk("R1 reset valid", int'(vld), 0);
    chk("R1 reset timeout", int'(err), 0);

    frame(16'h0000, 3, 25, 1'b0, 200, 1'b0);
    frame(16'hFFFF, 2, 30, 1'b0, 200, 1'b0);
    frame(16'h8001, 0, 12, 1'b0, 200, 1'b0);
    frame(16'h5AA5, 1, 40, 1'b0, 200, 1'b0);
    frame(16'hC3E7, 4, 22, 1'b0, 200, 1'b1);   // R9 held start
    for (int i = 0; i < 16; i++)
      frame(W'($urandom), 2 + int'($urandom % 5), ARM + 5 + int'($urandom % 60),
            1'b0, 200, i[2]);
    frame(16'h1234, 3, 20, 1'b1, 37, 1'b0);   // R8 muted converter
    frame(16'h4321, 3, 300, 1'b0, 50, 1'b0);  // R8 conversion too slow
    frame(16'hBEEF, 3, 20, 1'b0, 200, 1'b0);  // recovers after timeout

    // R7 back-pressure
    begin
      int b_rise;
      ready = 1'b0;
      m_word = 16'hA55A; m_ctime = 18; m_mute = 1'b0; cfg_half = 8'd2;
      start = 1'b1; tick(1); start = 1'b0;
      for (int g = 0; g < 2000 && !vld; g++) tick(1);
      tick(10);
      chk("R7 valid held", int'(vld), 1);
      chk("R7 data held", int'(data), 16'hA55A);
      b_rise = cnv_rises;
      start = 1'b1; tick(20); start = 1'b0;
      chk("R7 start ignored while pending", cnv_rises - b_rise, 0);
      chk("R7 data still held", int'(data), 16'hA55A);
      ready = 1'b1;
      tick(2);
      chk("R7 drained", int'(vld), 0);
      chk("R7 handshake word", int'(got_word), 16'hA55A);
    end

    chk("R3 clock only with select low", bad_sck, 0);
    chk("R6 select high before strobe drop", bad_close, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule